// File: doc/BRIEF.md
# Multi-bank selectable clock divider

This block derives four clock banks from one fast source clock: bank A, bank B, bank C and a feedback bank. Each bank divides by an even ratio picked by its own select code, and the ratio tables differ from bank to bank. A pre-divide stage sits ahead of all four banks and either passes every source edge through or only every second one. Each bank output toggles after half of its ratio, so its duty cycle is 50%. Bank C is fanned out to four outputs. An inversion select can flip the upper two of these outputs.

An active-low master reset clears every divider at once and holds all outputs low, with the enable flag low. The reset is asserted asynchronously and released through two synchronising flops. After release, every bank starts from the same source edge, so the banks keep a fixed phase relation to each other. A new ratio is taken up only at the end of a full output period, so no shortened high or low phase appears. Each bank also drives a one-cycle edge strobe that marks its rising edges, for use by neighbouring synchronisation and freeze logic.

Top module: `mbank_clk_div`

## Requirements
- R1: Bank A divides the pre-divided clock by 4, 6, 8 or 12 for `sel_a` values 0, 1, 2 and 3.
- R2: Bank B divides by 4, 6, 8 or 10 for `sel_b` values 0, 1, 2 and 3.
- R3: Bank C divides by 2, 4, 6 or 8 for `sel_c` values 0, 1, 2 and 3.
- R4: The feedback bank divides by 4, 6, 8, 10, 8, 12, 16 or 20 for `sel_fb` values 0 through 7 respectively.
- R5: With `prediv_off` high every source edge advances the banks (divide by 1). With it low only every second source edge does (divide by 2), and the first edge after reset release always counts.
- R6: While `rst_n` is low, all clock outputs, all edge strobes and `out_en` are low. They drop without waiting for a clock edge. With `rst_n` high, `out_en` is high.
- R7: After `rst_n` rises, `out_en` goes high after the second source rising edge. Every bank output and every non-inverted bank C output rises together at the third edge.
- R8: Each bank output stays high for ratio/2 advancing edges and low for ratio/2 advancing edges, repeating without gaps.
- R9: With `inv_c23` high, `clk_c[2]` and `clk_c[3]` are the complement of `clk_c[0]` outside reset. With it low, they equal `clk_c[0]`. `clk_c[0]` and `clk_c[1]` are never inverted.
- R10: A change to a bank's select code takes effect at the next rising edge of that bank's output. The period in progress completes at the old ratio.
- R11: Each bank's edge strobe is high for exactly the one source cycle after the source edge at which that bank's output rises, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low master reset, asynchronous assert |
| prediv_off | input | 1 | 1: no pre-divide, 0: pre-divide by two |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback bank ratio select |
| inv_c23 | input | 1 | Invert bank C outputs 2 and 3 |
| out_en | output | 1 | Outputs enabled (synchronised reset released) |
| clk_a | output | 1 | Bank A clock |
| clk_b | output | 1 | Bank B clock |
| clk_c | output | 4 | Bank C clocks; bits 3:2 optionally inverted |
| clk_fb | output | 1 | Feedback bank clock |
| edge_a | output | 1 | Bank A rising-edge strobe |
| edge_b | output | 1 | Bank B rising-edge strobe |
| edge_c | output | 1 | Bank C rising-edge strobe |
| edge_fb | output | 1 | Feedback bank rising-edge strobe |

## Verification
The hardest case to reach is a ratio change that arrives in the middle of a period. The design must finish the old period before it adopts the new ratio. To reach it, the stimulus changes bank A's select while the output is still in its first high phase. The bench then compares every later cycle against a waveform that completes one divide-by-4 period before switching to divide-by-12. The other cases are covered by a sweep of every feedback code, cycling the other banks' codes across all pre-divide and inversion settings. Each sweep run restarts from reset, so the aligned start and the release latency are checked every time.

// File: rtl/mbcd_pkg.sv
`timescale 1ns/1ps
package mbcd_pkg;

  localparam int HALF_W  = 4;
  localparam int SEL_MAX = 3;
  localparam int N_BANKS = 4;

  typedef enum logic [1:0] {
    BANK_A  = 2'd0,
    BANK_B  = 2'd1,
    BANK_C  = 2'd2,
    BANK_FB = 2'd3
  } bank_kind_e;

  // Half-period length in advancing ticks for a bank kind and select code.
  function automatic logic [HALF_W-1:0] half_of(bank_kind_e kind, logic [SEL_MAX-1:0] sel);
    logic [HALF_W-1:0] h;
    case (kind)
      BANK_A:  h = (sel[1:0] == 2'd3) ? HALF_W'(6) : HALF_W'(2) + HALF_W'(sel[1:0]);
      BANK_B:  h = HALF_W'(2) + HALF_W'(sel[1:0]);
      BANK_C:  h = HALF_W'(1) + HALF_W'(sel[1:0]);
      default: h = sel[2] ? HALF_W'(4) + HALF_W'({sel[1:0], 1'b0})
                          : HALF_W'(2) + HALF_W'(sel[1:0]);
    endcase
    return h;
  endfunction

endpackage

// File: rtl/mbcd_rst_sync.sv
`timescale 1ns/1ps
module mbcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mbcd_predivide.sv
`timescale 1ns/1ps
module mbcd_predivide (
  input  logic clk,
  input  logic rst_n,
  input  logic prediv_off,
  output logic tick
);

  logic alt_q;
  logic alt_d;

  always_comb begin
    alt_d = ~alt_q;
  end

  // Reset value 1 so the first edge after release always advances.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alt_q <= 1'b1;
    else        alt_q <= alt_d;
  end

  assign tick = prediv_off | alt_q;

  AST_PREDIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!prediv_off && tick) |=> (prediv_off || !tick)); // R5

endmodule

// File: rtl/mbcd_bank.sv
`timescale 1ns/1ps
module mbcd_bank #(
  parameter mbcd_pkg::bank_kind_e KIND = mbcd_pkg::BANK_A
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic [mbcd_pkg::SEL_MAX-1:0] sel,
  output logic                         phase_o,
  output logic                         strobe_o
);

  localparam int HW = mbcd_pkg::HALF_W;

  logic          phase_q, phase_d;
  logic          strobe_q, strobe_d;
  logic [HW-1:0] cnt_q, cnt_d;
  logic [HW-1:0] half_q, half_d;
  logic [HW-1:0] half_sel;

  always_comb begin
    half_sel = mbcd_pkg::half_of(KIND, sel);
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    half_d   = half_q;
    strobe_d = 1'b0;
    if (tick) begin
      if (cnt_q == '0) begin
        phase_d = ~phase_q;
        if (!phase_q) begin
          // period boundary: adopt the current select
          half_d   = half_sel;
          cnt_d    = half_sel - HW'(1);
          strobe_d = 1'b1;
        end else begin
          cnt_d = half_q - HW'(1);
        end
      end else begin
        cnt_d = cnt_q - HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      strobe_q <= 1'b0;
      cnt_q    <= '0;
      half_q   <= HW'(1);
    end else begin
      phase_q  <= phase_d;
      strobe_q <= strobe_d;
      cnt_q    <= cnt_d;
      half_q   <= half_d;
    end
  end

  assign phase_o  = phase_q;
  assign strobe_o = strobe_q;

  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_q)); // R8

  AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |=> $stable(half_q)); // R10

  AST_STROBE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> (phase_q && !$past(phase_q))); // R11

endmodule

// File: rtl/mbank_clk_div.sv
`timescale 1ns/1ps
module mbank_clk_div (
  input  logic       clk_src,
  input  logic       rst_n,
  input  logic       prediv_off,
  input  logic [1:0] sel_a,
  input  logic [1:0] sel_b,
  input  logic [1:0] sel_c,
  input  logic [2:0] sel_fb,
  input  logic       inv_c23,
  output logic       out_en,
  output logic       clk_a,
  output logic       clk_b,
  output logic [3:0] clk_c,
  output logic       clk_fb,
  output logic       edge_a,
  output logic       edge_b,
  output logic       edge_c,
  output logic       edge_fb
);

  import mbcd_pkg::*;

  logic                rst_sync_n;
  logic                tick;
  logic [SEL_MAX-1:0]  sel_all [N_BANKS];
  logic [N_BANKS-1:0]  phase;
  logic [N_BANKS-1:0]  strobe;

  mbcd_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk_src),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mbcd_predivide u_prediv (
    .clk        (clk_src),
    .rst_n      (rst_sync_n),
    .prediv_off (prediv_off),
    .tick       (tick)
  );

  assign sel_all[0] = {1'b0, sel_a};
  assign sel_all[1] = {1'b0, sel_b};
  assign sel_all[2] = {1'b0, sel_c};
  assign sel_all[3] = sel_fb;

  for (genvar k = 0; k < N_BANKS; k++) begin : g_bank
    mbcd_bank #(.KIND(bank_kind_e'(k))) u_bank (
      .clk      (clk_src),
      .rst_n    (rst_sync_n),
      .tick     (tick),
      .sel      (sel_all[k]),
      .phase_o  (phase[k]),
      .strobe_o (strobe[k])
    );
  end

  assign out_en  = rst_sync_n;
  assign clk_a   = phase[0];
  assign clk_b   = phase[1];
  assign clk_fb  = phase[3];
  assign clk_c   = {{2{(phase[2] ^ inv_c23) & rst_sync_n}}, {2{phase[2]}}};
  assign edge_a  = strobe[0];
  assign edge_b  = strobe[1];
  assign edge_c  = strobe[2];
  assign edge_fb = strobe[3];

  AST_ALIGNED_START: assert property (@(posedge clk_src) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |=> (clk_a && clk_b && clk_c[0] && clk_fb)); // R7

endmodule

// File: tb/tb_mbank_clk_div.sv
`timescale 1ns/1ps
module tb_mbank_clk_div;

  logic       clk_src = 1'b0;
  logic       rst_n;
  logic       prediv_off;
  logic [1:0] sel_a, sel_b, sel_c;
  logic [2:0] sel_fb;
  logic       inv_c23;
  logic       out_en, clk_a, clk_b, clk_fb;
  logic [3:0] clk_c;
  logic       edge_a, edge_b, edge_c, edge_fb;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam int RUN_LEN = 96;

  always #4 clk_src = ~clk_src;

  mbank_clk_div dut (
    .clk_src(clk_src), .rst_n(rst_n), .prediv_off(prediv_off),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
    .inv_c23(inv_c23), .out_en(out_en), .clk_a(clk_a), .clk_b(clk_b),
    .clk_c(clk_c), .clk_fb(clk_fb), .edge_a(edge_a), .edge_b(edge_b),
    .edge_c(edge_c), .edge_fb(edge_fb)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int ratio_a(int s);  return (s == 3) ? 12 : 4 + 2 * s; endfunction
  function automatic int ratio_b(int s);  return 4 + 2 * s; endfunction
  function automatic int ratio_c(int s);  return 2 * (s + 1); endfunction
  function automatic int ratio_fb(int s); return (s < 4) ? 4 + 2 * s : 8 + 4 * (s - 4); endfunction

  function automatic bit wave(int i, int ratio, int pre);
    return ((i / ((ratio / 2) * pre)) % 2) == 0;
  endfunction

  task automatic sample();
    @(posedge clk_src);
    #2;
  endtask

  // Reset, release, and stop on sample index 0 (first aligned high).
  task automatic restart(input int pa, input int sa, input int sb, input int sc,
                         input int sf, input int inv);
    @(negedge clk_src);
    rst_n = 1'b0;
    prediv_off = pa[0]; sel_a = 2'(sa); sel_b = 2'(sb); sel_c = 2'(sc);
    sel_fb = 3'(sf); inv_c23 = inv[0];
    #1;
    // R6: all outputs low while reset is held
    chk({out_en, clk_a, clk_b, clk_c, clk_fb, edge_a, edge_b, edge_c, edge_fb} == 0,
        "R6 outputs in reset", int'({clk_a, clk_b, clk_c, clk_fb}), 0);
    repeat (2) @(negedge clk_src);
    rst_n = 1'b1;
    sample();
    chk(!out_en && !clk_a, "R7 sample1 still held", int'({out_en, clk_a}), 0);
    sample();
    chk(out_en && !clk_a && !clk_fb, "R7 sample2 enabled but low", int'({out_en, clk_a, clk_fb}), 4);
    sample();
    chk(clk_a && clk_b && clk_c[0] && clk_c[1] && clk_fb,
        "R7 aligned first rise", int'({clk_a, clk_b, clk_c[1:0], clk_fb}), 5'h1f);
  endtask

  task automatic run_cfg(input int pa, input int sa, input int sb, input int sc,
                         input int sf, input int inv);
    int pre = pa ? 1 : 2;
    int ra = ratio_a(sa), rb = ratio_b(sb), rc = ratio_c(sc), rf = ratio_fb(sf);
    int ea = 0, eb = 0, ec = 0, ef = 0, ei = 0, es = 0;
    restart(pa, sa, sb, sc, sf, inv);
    for (int i = 0; i < RUN_LEN; i++) begin
      if (i > 0) sample();
      if (clk_a  !== wave(i, ra, pre)) ea++;
      if (clk_b  !== wave(i, rb, pre)) eb++;
      if (clk_c[0] !== wave(i, rc, pre) || clk_c[1] !== wave(i, rc, pre)) ec++;
      if (clk_fb !== wave(i, rf, pre)) ef++;
      if (clk_c[2] !== (wave(i, rc, pre) ^ inv[0]) || clk_c[3] !== (wave(i, rc, pre) ^ inv[0])) ei++;
      if (edge_a  !== ((i % (ra * pre)) == 0) || edge_b  !== ((i % (rb * pre)) == 0) ||
          edge_c  !== ((i % (rc * pre)) == 0) || edge_fb !== ((i % (rf * pre)) == 0)) es++;
    end
    chk(ea == 0, $sformatf("R1 R5 R8 bank A sel %0d pre %0d mismatching cycles", sa, pre), ea, 0);
    chk(eb == 0, $sformatf("R2 R5 R8 bank B sel %0d pre %0d mismatching cycles", sb, pre), eb, 0);
    chk(ec == 0, $sformatf("R3 R5 R8 bank C sel %0d pre %0d mismatching cycles", sc, pre), ec, 0);
    chk(ef == 0, $sformatf("R4 R5 R8 feedback sel %0d pre %0d mismatching cycles", sf, pre), ef, 0);
    chk(ei == 0, $sformatf("R9 bank C upper pair inv %0d mismatching cycles", inv), ei, 0);
    chk(es == 0, $sformatf("R11 edge strobes pre %0d mismatching cycles", pre), es, 0);
  endtask

  // Bank A switches from ratio 4 to 12 during its first high phase.
  task automatic sel_change();
    int errs = 0;
    bit exp;
    restart(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 22; i++) begin
      if (i > 0) sample();
      if (i == 1) begin
        @(negedge clk_src);
        sel_a = 2'd3;
      end
      exp = (i < 2) || (i >= 4 && i < 10) || (i >= 16);
      if (i > 1 || i == 0) begin
        if (clk_a !== exp) errs++;
      end
      if (i == 1 && clk_a !== 1'b1) errs++;
    end
    chk(errs == 0, "R10 ratio change waits for period end", errs, 0);
  endtask

  // Reset asserted while outputs are high drops them without a clock edge.
  task automatic async_reset();
    restart(1, 1, 1, 1, 1, 1);
    @(posedge clk_src);
    #3;
    rst_n = 1'b0;
    #1;
    chk({out_en, clk_a, clk_b, clk_c, clk_fb} == 0,
        "R6 asynchronous clear", int'({out_en, clk_a, clk_b, clk_c, clk_fb}), 0);
    @(negedge clk_src);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; prediv_off = 1'b1; inv_c23 = 1'b0;
    sel_a = 2'd0; sel_b = 2'd0; sel_c = 2'd0; sel_fb = 3'd0;
    repeat (3) @(negedge clk_src);
    for (int pa = 0; pa < 2; pa++) begin
      for (int k = 0; k < 8; k++) begin
        run_cfg(pa, k % 4, (k + 1) % 4, (k + 2) % 4, k, k % 2);
      end
    end
    sel_change();
    async_reset();
    finish_run();
  end

endmodule